// File: doc/BRIEF.md
# Bit Scan, Bit Test and Funnel Shift Unit

A single-stage execution unit for W-bit (default 32) words. Each cycle with `valid_i` high it accepts one operation, a destination word, a source word and a count, and one clock later presents the result word together with a zero flag and a carry flag. The operations cover three groups. Two bit scans find the lowest or the highest set bit of the source. Four test operations read one bit of the destination into carry and may then flip, clear or set that bit. Two funnel shifts move the destination left or right and fill the vacated positions from the opposite end of the source.

The flags are held in registers. An operation updates only the flags it defines and leaves the others as the earlier operations left them. A cycle with `valid_i` low changes nothing. The unit is meant to sit behind an instruction decoder that supplies register operands and takes the flags back into its own flag state. W must be a power of two.

Top module: `bitops_unit`

## Requirements
- R1: With op code 0 (scan up) and a nonzero source, the result is the index of the least significant 1 in `src_i`, zero-extended, and `zf_o` is 0.
- R2: With op code 1 (scan down) and a nonzero source, the result is the index of the most significant 1 in `src_i`, and `zf_o` is 0.
- R3: For either scan with `src_i` equal to zero, `zf_o` becomes 1 and the result equals `dst_i`.
- R4: Scans leave `cf_o` unchanged. Test operations (op codes 2 to 5) leave `zf_o` unchanged. Shifts never change `zf_o`.
- R5: With op code 2 (test), `cf_o` takes bit `dst_i[k]`, where k is the bit index, and the result equals `dst_i`.
- R6: Op codes 3, 4 and 5 load carry as in R5 and then return `dst_i` with bit k complemented (3), cleared (4) or set (5). All other bits are unchanged.
- R7: The bit index k is `src_i[4:0]`, which is the index modulo 32. The upper source bits have no effect.
- R8: With op code 6 (double left) and count c = `cnt_i` in the range 1..31, the result is `dst_i` shifted left by c, with the low c bits taken from the top c bits of `src_i`.
- R9: With op code 7 (double right) and c in the range 1..31, the result is `dst_i` shifted right by c, with the high c bits taken from the low c bits of `src_i`.
- R10: For a shift with c equal to 0, the result equals `dst_i` and both flags keep their values.
- R11: For a shift with c in 1..31, `cf_o` holds the last destination bit shifted out. That bit is `dst_i[32-c]` for a left shift and `dst_i[c-1]` for a right shift.
- R12: Results appear exactly one cycle after `valid_i`, and `valid_o` is high in that cycle. While `valid_i` is low, the result and both flags hold their values.
- R13: After reset, `res_o`, `zf_o`, `cf_o` and `valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept an operation this cycle |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| dst_i | input | W | Destination operand |
| src_i | input | W | Source operand: scan word, bit index, or shift fill |
| cnt_i | input | log2(W) | Shift count |
| valid_o | output | 1 | Result valid |
| res_o | output | W | Result word |
| zf_o | output | 1 | Zero flag (scan found nothing) |
| cf_o | output | 1 | Carry flag (tested bit or last bit shifted out) |

## Verification
The two functions that meet in one cycle are flag production and flag preservation. A scan writes only the zero flag. A test writes only carry. A zero-count shift writes neither. So the flags seen after any operation mix values that different operations left in earlier cycles. The bench issues back-to-back streams of random operations, with all-zero sources and zero counts mixed in at a raised rate. A behavioural reference keeps its own flag state and compares both flags and the result after every cycle. This catches any flag that is wrongly cleared or overwritten.

// File: rtl/bitops_pkg.sv
package bitops_pkg;
  typedef enum logic [2:0] {
    OP_SCAN_UP  = 3'd0,
    OP_SCAN_DN  = 3'd1,
    OP_TEST     = 3'd2,
    OP_TEST_CPL = 3'd3,
    OP_TEST_CLR = 3'd4,
    OP_TEST_SET = 3'd5,
    OP_SHL_DBL  = 3'd6,
    OP_SHR_DBL  = 3'd7
  } bitop_e;
endpackage

// File: rtl/bitops_scan.sv
module bitops_scan #(
  parameter int W       = 32,
  parameter bit FROM_MS = 1'b0,
  localparam int IW     = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  assign found_o = |vec_i;

  // the last hit in loop order wins
  generate
    if (FROM_MS) begin : g_ms
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++)
          if (vec_i[i]) idx_o = IW'(i);
      end
    end else begin : g_ls
      always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--)
          if (vec_i[i]) idx_o = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/bitops_bitmod.sv
module bitops_bitmod
  import bitops_pkg::*;
#(
  parameter int W   = 32,
  localparam int IW = $clog2(W)
) (
  input  bitop_e        op_i,
  input  logic [W-1:0]  data_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  res_o,
  output logic          old_o
);
  logic new_bit;

  assign old_o = data_i[idx_i];

  always_comb begin
    unique case (op_i)
      OP_TEST_CPL: new_bit = ~old_o;
      OP_TEST_CLR: new_bit = 1'b0;
      OP_TEST_SET: new_bit = 1'b1;
      default:     new_bit = old_o;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res_o[i] = (idx_i == IW'(i)) ? new_bit : data_i[i];
  end
endmodule

// File: rtl/bitops_funnel.sv
module bitops_funnel #(
  parameter int W   = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          left_i,
  input  logic [W-1:0]  dst_i,
  input  logic [W-1:0]  src_i,
  input  logic [IW-1:0] cnt_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  logic [2*W-1:0] stage [IW+1];
  logic [IW-1:0]  amt;
  logic [IW-1:0]  cidx;

  // a left shift by c is a right shift of {dst,src} by W-c; W is a power of two
  assign amt      = left_i ? (~cnt_i + 1'b1) : cnt_i;
  assign cidx     = left_i ? (~cnt_i + 1'b1) : (cnt_i - 1'b1);
  assign stage[0] = left_i ? {dst_i, src_i} : {src_i, dst_i};

  for (genvar k = 0; k < IW; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign res_o   = stage[IW][W-1:0];
  assign carry_o = dst_i[cidx];
endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
  import bitops_pkg::*;
#(
  parameter int W   = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  dst_i,
  input  logic [W-1:0]  src_i,
  input  logic [IW-1:0] cnt_i,
  output logic          valid_o,
  output logic [W-1:0]  res_o,
  output logic          zf_o,
  output logic          cf_o
);
  bitop_e        op;
  logic [IW-1:0] up_idx, dn_idx;
  logic          up_found, dn_found;
  logic [W-1:0]  bm_res, fn_res;
  logic          bm_old, fn_cf;
  logic [W-1:0]  res_d;
  logic          zf_d, cf_d;

  assign op = bitop_e'(op_i);

  bitops_scan #(.W(W), .FROM_MS(1'b0)) u_scan_up (
    .vec_i(src_i), .idx_o(up_idx), .found_o(up_found)
  );
  bitops_scan #(.W(W), .FROM_MS(1'b1)) u_scan_dn (
    .vec_i(src_i), .idx_o(dn_idx), .found_o(dn_found)
  );
  bitops_bitmod #(.W(W)) u_bitmod (
    .op_i(op), .data_i(dst_i), .idx_i(src_i[IW-1:0]),
    .res_o(bm_res), .old_o(bm_old)
  );
  bitops_funnel #(.W(W)) u_funnel (
    .left_i(op == OP_SHL_DBL), .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i),
    .res_o(fn_res), .carry_o(fn_cf)
  );

  always_comb begin
    res_d = res_o;
    zf_d  = zf_o;
    cf_d  = cf_o;
    if (valid_i) begin
      unique case (op)
        OP_SCAN_UP: begin
          zf_d  = ~up_found;
          res_d = up_found ? {{(W-IW){1'b0}}, up_idx} : dst_i;
        end
        OP_SCAN_DN: begin
          zf_d  = ~dn_found;
          res_d = dn_found ? {{(W-IW){1'b0}}, dn_idx} : dst_i;
        end
        OP_TEST, OP_TEST_CPL, OP_TEST_CLR, OP_TEST_SET: begin
          cf_d  = bm_old;
          res_d = bm_res;
        end
        default: begin
          if (cnt_i != '0) begin
            res_d = fn_res;
            cf_d  = fn_cf;
          end else begin
            res_d = dst_i;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      zf_o    <= 1'b0;
      cf_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      res_o   <= res_d;
      zf_o    <= zf_d;
      cf_o    <= cf_d;
    end
  end
endmodule

// File: rtl/bitops_unit_chk.sv
module bitops_unit_chk #(
  parameter int W   = 32,
  localparam int IW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [W-1:0]  dst_i,
  input logic [W-1:0]  src_i,
  input logic [IW-1:0] cnt_i,
  input logic          valid_o,
  input logic [W-1:0]  res_o,
  input logic          zf_o,
  input logic          cf_o
);
  logic is_test;
  assign is_test = (op_i >= 3'd2) && (op_i <= 3'd5);

  a_r1_scan_up_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd0 && src_i != '0 |=>
      !zf_o && (res_o >> IW) == '0 &&
      ((($past(src_i) >> res_o[IW-1:0]) & W'(1)) == W'(1)) &&
      (($past(src_i) & ((W'(1) << res_o[IW-1:0]) - W'(1))) == '0));

  a_r2_scan_dn_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 && src_i != '0 |=>
      !zf_o && (res_o >> IW) == '0 &&
      (($past(src_i) >> res_o[IW-1:0]) == W'(1)));

  a_r3_scan_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= 3'd1 && src_i == '0 |=> zf_o && res_o == $past(dst_i));

  a_r4_scan_keeps_cf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= 3'd1 |=> $stable(cf_o));

  a_r4_test_keeps_zf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 3'd2 |=> $stable(zf_o));

  a_r5_test_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_test |=>
      cf_o == (($past(dst_i) >> $past(src_i[IW-1:0])) & W'(1)) != '0);

  a_r6_test_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_test |=>
      ((res_o ^ $past(dst_i)) & ~(W'(1) << $past(src_i[IW-1:0]))) == '0);

  a_r10_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 3'd6 && cnt_i == '0 |=>
      res_o == $past(dst_i) && $stable(cf_o) && $stable(zf_o));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(zf_o) && $stable(cf_o));

  a_r12_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

bind bitops_unit bitops_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bitops_unit.sv
module tb_bitops_unit;
  localparam int W  = 32;
  localparam int IW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [W-1:0]  dst_i = '0;
  logic [W-1:0]  src_i = '0;
  logic [IW-1:0] cnt_i = '0;
  logic          valid_o, zf_o, cf_o;
  logic [W-1:0]  res_o;

  int total = 0;
  int bad   = 0;

  // reference state
  logic [W-1:0] m_res = '0;
  logic         m_zf  = 1'b0;
  logic         m_cf  = 1'b0;
  logic         m_vld = 1'b0;

  always #5 clk_i = ~clk_i;

  bitops_unit #(.W(W)) dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .dst_i, .src_i, .cnt_i,
    .valid_o, .res_o, .zf_o, .cf_o
  );

  task automatic check(string tag);
    total++;
    if (res_o !== m_res || zf_o !== m_zf || cf_o !== m_cf || valid_o !== m_vld) begin
      bad++;
      $display("FAIL %s: got res=%h zf=%b cf=%b v=%b, expected res=%h zf=%b cf=%b v=%b",
               tag, res_o, zf_o, cf_o, valid_o, m_res, m_zf, m_cf, m_vld);
    end
  endtask

  function automatic string tag_of(int op, logic [W-1:0] s, int c);
    case (op)
      0: return (s == 0) ? "R3 scan up empty" : "R1 scan up";
      1: return (s == 0) ? "R3 scan down empty" : "R2 scan down";
      2: return "R5 R7 test";
      3, 4, 5: return "R6 R7 test modify";
      6: return (c == 0) ? "R10 shl zero" : "R8 R11 shl";
      default: return (c == 0) ? "R10 shr zero" : "R9 R11 shr";
    endcase
  endfunction

  // behavioural model, bit by bit
  task automatic model(int op, logic [W-1:0] d, logic [W-1:0] s, int c);
    int k;
    logic [W-1:0] sh;
    m_vld = 1'b1;
    case (op)
      0: begin
        m_zf = (s == 0); m_res = d;
        for (int i = W - 1; i >= 0; i--) if (s[i]) m_res = W'(i);
      end
      1: begin
        m_zf = (s == 0); m_res = d;
        for (int i = 0; i < W; i++) if (s[i]) m_res = W'(i);
      end
      2, 3, 4, 5: begin
        k = s % 32;
        m_cf = d[k]; m_res = d;
        if (op == 3) m_res[k] = ~d[k];
        if (op == 4) m_res[k] = 1'b0;
        if (op == 5) m_res[k] = 1'b1;
      end
      6: begin
        m_res = d; sh = s;
        for (int i = 0; i < c; i++) begin
          m_cf = m_res[W-1]; m_res = {m_res[W-2:0], sh[W-1]}; sh = sh << 1;
        end
      end
      default: begin
        m_res = d; sh = s;
        for (int i = 0; i < c; i++) begin
          m_cf = m_res[0]; m_res = {sh[0], m_res[W-1:1]}; sh = sh >> 1;
        end
      end
    endcase
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic issue(int op, logic [W-1:0] d, logic [W-1:0] s, int c, string tag);
    valid_i = 1'b1; op_i = 3'(op); dst_i = d; src_i = s; cnt_i = IW'(c);
    model(op, d, s, c);
    @(posedge clk_i); @(negedge clk_i);
    check(tag);
  endtask

  task automatic idle(string tag);
    valid_i = 1'b0; dst_i = 32'hDEAD_BEEF; src_i = 32'h1; op_i = 3'd5; cnt_i = 5'd3;
    m_vld = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check(tag);
  endtask

  initial begin : watchdog
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] d, s;
    int op, c;
    repeat (3) @(negedge clk_i);
    check("R13 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R13 after release");

    issue(0, 32'h1234_5678, 32'h0000_0A00, 0, "R1 scan up mid");
    issue(0, 32'h0, 32'h8000_0000, 0, "R1 scan up top bit");
    issue(1, 32'h0, 32'h0000_0001, 0, "R2 scan down bit0");
    issue(1, 32'h0, 32'h0F00_0010, 0, "R2 scan down mid");
    issue(0, 32'hCAFE_F00D, 32'h0, 0, "R3 scan up empty keeps dst");
    issue(2, 32'h0000_0100, 32'hFFFF_FFE8, 0, "R5 R7 test index 8 via high bits");
    issue(1, 32'hABCD_0123, 32'h0, 0, "R3 R4 empty scan keeps carry");
    issue(3, 32'hFFFF_FFFF, 32'd31, 0, "R6 complement bit31");
    issue(4, 32'h0000_00F0, 32'd4, 0, "R6 clear bit4");
    issue(5, 32'h0, 32'd63, 0, "R6 R7 set bit31 via 63");
    issue(2, 32'h0, 32'd0, 0, "R4 R5 test keeps zf");
    issue(7, 32'h1234_5678, 32'hAABB_CCDD, 8, "R9 R11 shr 8");
    issue(6, 32'h8123_4567, 32'hF000_0000, 1, "R8 R11 shl 1");
    issue(6, 32'h0000_0003, 32'h7FFF_FFFF, 31, "R8 R11 shl 31");
    issue(7, 32'h8000_0001, 32'h0000_0001, 31, "R9 R11 shr 31");
    issue(6, 32'h5555_AAAA, 32'hFFFF_FFFF, 0, "R10 shl zero count");
    issue(7, 32'hAAAA_5555, 32'hFFFF_FFFF, 0, "R10 shr zero count");
    idle("R12 idle hold");
    idle("R12 idle hold twice");

    for (int n = 0; n < 400; n++) begin
      op = $urandom_range(7);
      d  = $urandom;
      s  = ($urandom_range(3) == 0) ? 32'h0 : (32'h1 << $urandom_range(31)) | ($urandom & $urandom);
      c  = ($urandom_range(4) == 0) ? 0 : $urandom_range(31);
      if ($urandom_range(9) == 0) idle("R12 random idle");
      issue(op, d, s, c, tag_of(op, s, c));
    end
    idle("R12 final idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule